// File: doc/BRIEF.md
# Memory-mapped hash DMA engine

This block is a bus-attached hashing accelerator that sits on a 16-bit address, 8-bit data bus and owns a byte-wide RAM. Software programs a source pointer, a destination pointer and a byte length through a 16-byte control window, then issues a go command. The engine walks the source buffer in 64-byte chunks. For each chunk it presents the chunk together with the running 160-bit digest to an external combinational compression port and keeps the returned value as the new digest. Once the length is covered it stores the 20 digest bytes back into RAM and returns to idle.

Every bus cycle carries a 4-bit operation code. Bits [3:2] select the bus action: 01 reads and 10 writes. Bit 1 is a step enable, and the sequencer moves only in cycles where it is set. Bus traffic outside the window goes straight to the RAM, so the bench, or software, fills the source buffer and collects the digest through the same port.

Top module: `hashdma_engine`

## Requirements
- R1: An op code with bits [3:2]=01 reads and one with 10 writes. Outside the window 0xFE00..0xFE0F, a read returns the RAM byte at the address modulo the RAM size and a write stores that byte. busRdData is 0x00 in any cycle that is not a read.
- R2: Window offsets are 0x0 go (write only, reads 0x00), 0x1 sequencer state, 0x2/0x3 source pointer low/high byte, 0x4/0x5 destination pointer low/high byte, 0x6/0x7 length low/high byte. Offsets 0x8..0xF read as 0x00.
- R3: A bus write inside the window never changes any RAM byte.
- R4: The state reads back as IDLE=0, FETCH=1, MIX=2, FLUSH=3, with the upper six bits zero. After reset the state is IDLE and all pointer and length bytes read 0x00.
- R5: In IDLE, a write to offset 0x0 with data bit 0 set moves the engine to FETCH. The same write with bit 0 clear leaves it in IDLE.
- R6: Outside IDLE, writes to the pointer and length registers and go commands have no effect.
- R7: The sequencer holds its state in every cycle where op bit 1 is clear.
- R8: A FETCH step loads chunk byte i (bits [8i+7:8i]) from RAM at source + processed + i for i = 0..63, adds 64 to the processed count and enters MIX.
- R9: mixIn is {chunk, digest} with the digest in bits [159:0]. A MIX step replaces the digest with mixOut, then enters FETCH if processed < length and FLUSH otherwise.
- R10: A FLUSH step writes digest byte i (bits [8i+7:8i]) to RAM at destination + processed + i for i = 0..19, touches no other byte and returns to IDLE.
- R11: A go command zeroes the processed count and the digest, so each job starts from an all-zero digest.
- R12: A length of zero still hashes exactly one chunk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busOp | input | 4 | [3:2] bus action (01 read, 10 write), [1] sequencer step |
| busAddr | input | 16 | Bus byte address |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Combinational bus read data |
| mixIn | output | 672 | Compression input {chunk, digest} |
| mixOut | input | 160 | Compression result |

## Verification
The hardest condition to reach is the FETCH/MIX loop closing on the correct chunk. The decision depends on a count that is only visible through the RAM addresses of the final write-out, so an off-by-one in the comparison or the count shows up only at lengths just around multiples of 64. The stimulus therefore sweeps lengths 0, 1, 63, 64, 65, 127, 128, 129 and 192 from both an aligned and an unaligned source. It predicts the chunk count, each chunk, the state after every step and the address of every digest byte arithmetically. Each job also pokes the busy engine with register writes, go commands and step-less cycles before letting it advance.

// File: rtl/hashdma_pkg.sv
package hashdma_pkg;

  // Sequencer states; the encoding is visible on the bus.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_MIX   = 2'd2,
    SEQ_FLUSH = 2'd3
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic busRd;     // bus read this cycle
    logic busWr;     // bus write this cycle
    logic inWindow;  // address hits the control window
    logic cfgWr;     // window write accepted (IDLE only)
    logic start;     // go command accepted
    logic fetch;     // FETCH step
    logic mix;       // MIX step
    logic flush;     // FLUSH step
  } dmaStrobes_t;

  localparam int unsigned WIN_AW = 4;

  // Window offsets and register groups (offset[3:1]).
  localparam logic [WIN_AW-1:0] OFS_GO    = 4'h0;
  localparam logic [WIN_AW-1:0] OFS_STATE = 4'h1;
  localparam logic [2:0] GRP_SRC = 3'd1;
  localparam logic [2:0] GRP_DST = 3'd2;
  localparam logic [2:0] GRP_LEN = 3'd3;

endpackage

// File: rtl/hashdma_ctrl.sv
module hashdma_ctrl
  import hashdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              goBit,
  input  logic              moreData,
  output dmaStrobes_t       stb,
  output seqState_t         state
);

  logic unusedOpBit;
  assign unusedOpBit = op[0];

  logic step;
  logic isIdle;
  logic [WIN_AW-1:0] offset;
  seqState_t nextState;

  assign step   = op[1];
  assign isIdle = (state == SEQ_IDLE);
  assign offset = addr[WIN_AW-1:0];

  always_comb begin
    stb          = '0;
    stb.busRd    = (op[3:2] == 2'b01);
    stb.busWr    = (op[3:2] == 2'b10);
    stb.inWindow = (addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
    stb.cfgWr    = stb.busWr && stb.inWindow && isIdle;
    stb.start    = stb.cfgWr && (offset == OFS_GO) && goBit;
    stb.fetch    = (state == SEQ_FETCH) && step;
    stb.mix      = (state == SEQ_MIX) && step;
    stb.flush    = (state == SEQ_FLUSH) && step;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_IDLE:  if (stb.start) nextState = SEQ_FETCH;
      SEQ_FETCH: if (step) nextState = SEQ_MIX;
      SEQ_MIX:   if (step) nextState = moreData ? SEQ_FETCH : SEQ_FLUSH;
      SEQ_FLUSH: if (step) nextState = SEQ_IDLE;
      default:   nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  // R7: no movement outside IDLE without the step bit
  a_r7_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE && !op[1]) |=> $stable(state));

  // R5: accepted go command enters FETCH
  a_r5_go_enters_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && op[3:2] == 2'b10 && addr == WIN_BASE && goBit) |=> (state == SEQ_FETCH));

  // R9: last chunk mixed leads to FLUSH
  a_r9_last_chunk_flush: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_MIX && op[1] && !moreData) |=> (state == SEQ_FLUSH));

  // R10: write-out returns to IDLE
  a_r10_flush_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_FLUSH && op[1]) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/hashdma_datapath.sv
module hashdma_datapath
  import hashdma_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RAM_AW       = 9,
  parameter int unsigned CHUNK_BYTES  = 64,
  parameter int unsigned DIGEST_BYTES = 20
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dmaStrobes_t                            stb,
  input  seqState_t                              state,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [DATA_W-1:0]                      wrData,
  output logic [DATA_W-1:0]                      rdData,
  output logic                                   moreData,
  output logic [CHUNK_BYTES*DATA_W+DIGEST_BYTES*DATA_W-1:0] mixIn,
  input  logic [DIGEST_BYTES*DATA_W-1:0]         mixOut
);

  localparam int unsigned CHUNK_W   = CHUNK_BYTES * DATA_W;
  localparam int unsigned DIGEST_W  = DIGEST_BYTES * DATA_W;
  localparam int unsigned RAM_DEPTH = 1 << RAM_AW;

  logic unusedAddrHi;
  assign unusedAddrHi = ^addr[ADDR_W-1:RAM_AW];

  logic [ADDR_W-1:0]   srcAddr;
  logic [ADDR_W-1:0]   dstAddr;
  logic [ADDR_W-1:0]   lenReg;
  logic [ADDR_W-1:0]   processed;
  logic [CHUNK_W-1:0]  chunk;
  logic [DIGEST_W-1:0] digest;
  logic [DATA_W-1:0]   ram [RAM_DEPTH];

  logic [WIN_AW-1:0]   offset;
  logic [2:0]          group;
  logic                hiByte;
  logic [RAM_AW-1:0]   busIdx;
  logic [CHUNK_W-1:0]  fetchBytes;
  logic [RAM_AW-1:0]   flushIdx [DIGEST_BYTES];

  assign offset   = addr[WIN_AW-1:0];
  assign group    = offset[WIN_AW-1:1];
  assign hiByte   = offset[0];
  assign busIdx   = addr[RAM_AW-1:0];
  assign moreData = (processed < lenReg);
  assign mixIn    = {chunk, digest};

  // Gather one chunk from RAM.
  for (genvar i = 0; i < CHUNK_BYTES; i++) begin : g_fetch
    logic [ADDR_W-1:0] fAddr;
    assign fAddr = srcAddr + processed + ADDR_W'(i);
    assign fetchBytes[i*DATA_W +: DATA_W] = ram[fAddr[RAM_AW-1:0]];
  end

  // Destination slots of the digest write-out.
  for (genvar i = 0; i < DIGEST_BYTES; i++) begin : g_flush
    logic [ADDR_W-1:0] wAddr;
    assign wAddr       = dstAddr + processed + ADDR_W'(i);
    assign flushIdx[i] = wAddr[RAM_AW-1:0];
  end

  function automatic logic [ADDR_W-1:0] putByte(input logic [ADDR_W-1:0] cur,
                                                input logic hi,
                                                input logic [DATA_W-1:0] val);
    logic [ADDR_W-1:0] res;
    res = cur;
    if (hi) res[ADDR_W-1:DATA_W] = val;
    else    res[DATA_W-1:0]      = val;
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] getByte(input logic [ADDR_W-1:0] cur,
                                                input logic hi);
    return hi ? cur[ADDR_W-1:DATA_W] : cur[DATA_W-1:0];
  endfunction

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      lenReg  <= '0;
    end else if (stb.cfgWr) begin
      unique case (group)
        GRP_SRC: srcAddr <= putByte(srcAddr, hiByte, wrData);
        GRP_DST: dstAddr <= putByte(dstAddr, hiByte, wrData);
        GRP_LEN: lenReg  <= putByte(lenReg, hiByte, wrData);
        default: ;
      endcase
    end
  end

  // Job progress, chunk and digest.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      processed <= '0;
      chunk     <= '0;
      digest    <= '0;
    end else begin
      if (stb.start) begin
        processed <= '0;
        digest    <= '0;
      end
      if (stb.fetch) begin
        chunk     <= fetchBytes;
        processed <= processed + ADDR_W'(CHUNK_BYTES);
      end
      if (stb.mix) digest <= mixOut;
    end
  end

  // Byte RAM: bus writes outside the window, then digest write-out.
  always_ff @(posedge clk) begin
    if (stb.busWr && !stb.inWindow) ram[busIdx] <= wrData;
    if (stb.flush) begin
      for (int i = 0; i < DIGEST_BYTES; i++)
        ram[flushIdx[i]] <= digest[i*DATA_W +: DATA_W];
    end
  end

  // Bus read mux.
  always_comb begin
    rdData = '0;
    if (stb.busRd) begin
      if (stb.inWindow) begin
        if (offset == OFS_STATE) rdData = {{(DATA_W-2){1'b0}}, state};
        else begin
          unique case (group)
            GRP_SRC: rdData = getByte(srcAddr, hiByte);
            GRP_DST: rdData = getByte(dstAddr, hiByte);
            GRP_LEN: rdData = getByte(lenReg, hiByte);
            default: rdData = '0;
          endcase
        end
      end else begin
        rdData = ram[busIdx];
      end
    end
  end

  // R3: window writes leave RAM alone
  a_r3_window_keeps_ram: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busWr && stb.inWindow && !stb.flush) |=> (ram[$past(busIdx)] == $past(ram[busIdx])));

  // R6: configuration frozen while a job runs
  a_r6_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE) |=> ($stable(srcAddr) && $stable(dstAddr) && $stable(lenReg)));

  // R8: each fetch advances the count by one chunk
  a_r8_count_per_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_FETCH && stb.fetch) |=> (processed == $past(processed) + ADDR_W'(CHUNK_BYTES)));

  // R11: go command clears count and digest
  a_r11_go_clears: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && stb.start) |=> (processed == '0 && digest == '0));

endmodule

// File: rtl/hashdma_engine.sv
module hashdma_engine
  import hashdma_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RAM_AW       = 9,
  parameter int unsigned CHUNK_BYTES  = 64,
  parameter int unsigned DIGEST_BYTES = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          busOp,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic [(CHUNK_BYTES+DIGEST_BYTES)*DATA_W-1:0] mixIn,
  input  logic [DIGEST_BYTES*DATA_W-1:0] mixOut
);

  dmaStrobes_t stb;
  seqState_t   state;
  logic        moreData;

  hashdma_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .op      (busOp),
    .addr    (busAddr),
    .goBit   (busWrData[0]),
    .moreData(moreData),
    .stb     (stb),
    .state   (state)
  );

  hashdma_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RAM_AW      (RAM_AW),
    .CHUNK_BYTES (CHUNK_BYTES),
    .DIGEST_BYTES(DIGEST_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .state   (state),
    .addr    (busAddr),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .moreData(moreData),
    .mixIn   (mixIn),
    .mixOut  (mixOut)
  );

endmodule

// File: tb/tb_hashdma_engine.sv
module tb_hashdma_engine;

  localparam int RAM_SZ = 512;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   busOp = 4'h0;
  logic [15:0]  busAddr = 16'h0;
  logic [7:0]   busWrData = 8'h0;
  logic [7:0]   busRdData;
  logic [671:0] mixIn;
  logic [159:0] mixOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mirror [RAM_SZ];

  // Compression stub owned by the bench.
  function automatic logic [159:0] mixFn(input logic [671:0] x);
    logic [159:0] d;
    logic [511:0] c;
    d = x[159:0];
    c = x[671:160];
    return {d[158:0], d[159]} ^ c[159:0] ^ c[319:160] ^ c[479:320]
           ^ {128'd0, c[511:480]} ^ 160'h1;
  endfunction

  assign mixOut = mixFn(mixIn);

  always #2.5 clk = ~clk;

  hashdma_engine dut (
    .clk(clk), .rstN(rstN), .busOp(busOp), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mixIn(mixIn), .mixOut(mixOut)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busOp = 4'b1000; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busOp = 4'b0000;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busOp = 4'b0100; busAddr = a;
    #1 d = busRdData;
    busOp = 4'b0000;
  endtask

  task automatic stepOnce();
    @(negedge clk);
    busOp = 4'b0010;
    @(posedge clk); #1;
    busOp = 4'b0000;
  endtask

  task automatic memWrite(input logic [15:0] a, input logic [7:0] d);
    busWrite(a, d);
    mirror[a % RAM_SZ] = d;
  endtask

  task automatic runJob(input logic [15:0] src, input logic [15:0] dst, input logic [15:0] len);
    logic [7:0]   rd;
    logic [159:0] dig;
    logic [511:0] chk;
    logic [15:0]  proc;
    logic         more;
    busWrite(16'hFE02, src[7:0]);  busWrite(16'hFE03, src[15:8]);
    busWrite(16'hFE04, dst[7:0]);  busWrite(16'hFE05, dst[15:8]);
    busWrite(16'hFE06, len[7:0]);  busWrite(16'hFE07, len[15:8]);
    busWrite(16'hFE00, 8'h01);
    busRead(16'hFE01, rd); check("R5 go enters FETCH", rd, 1);
    repeat (3) @(negedge clk);
    busRead(16'hFE01, rd); check("R7 no step holds", rd, 1);
    busWrite(16'hFE02, ~src[7:0]);
    busRead(16'hFE02, rd); check("R6 busy cfg write ignored", rd, src[7:0]);
    busWrite(16'hFE00, 8'h01);
    busRead(16'hFE01, rd); check("R6 busy go ignored", rd, 1);
    dig = '0; proc = 0;
    do begin
      for (int i = 0; i < 64; i++) chk[i*8 +: 8] = mirror[(src + proc + 16'(i)) % RAM_SZ];
      stepOnce();
      check("R8 chunk bytes", mixIn[671:160], chk);
      check("R11 R9 digest input", mixIn[159:0], dig);
      busRead(16'hFE01, rd); check("R8 FETCH to MIX", rd, 2);
      busWrite(16'hFE00, 8'h01);
      busRead(16'hFE01, rd); check("R6 go ignored in MIX", rd, 2);
      dig = mixFn({chk, dig});
      proc = proc + 16'd64;
      more = (proc < len);
      stepOnce();
      busRead(16'hFE01, rd); check("R9 MIX next state", rd, more ? 1 : 3);
    end while (more);
    stepOnce();
    busRead(16'hFE01, rd); check("R10 FLUSH to IDLE", rd, 0);
    for (int i = 0; i < 20; i++) mirror[(dst + proc + 16'(i)) % RAM_SZ] = dig[i*8 +: 8];
    for (int i = 0; i < 20; i++) begin
      busRead(dst + proc + 16'(i), rd); check("R10 digest byte", rd, dig[i*8 +: 8]);
    end
    busRead(dst + proc - 16'd1, rd); check("R10 guard below", rd, mirror[(dst + proc - 16'd1) % RAM_SZ]);
    busRead(dst + proc + 16'd20, rd); check("R10 guard above", rd, mirror[(dst + proc + 16'd20) % RAM_SZ]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    logic [15:0] lens [9];
    lens = '{16'd0, 16'd1, 16'd63, 16'd64, 16'd65, 16'd127, 16'd128, 16'd129, 16'd192};
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R4 reset state
    busRead(16'hFE01, rd); check("R4 reset state", rd, 0);
    for (int o = 2; o < 8; o++) begin
      busRead(16'hFE00 + 16'(o), rd); check("R4 reset register byte", rd, 0);
    end

    // R1 fill RAM through the bus
    for (int a = 0; a < RAM_SZ; a++) memWrite(16'(a), 8'((a * 37 + 11) & 255));
    for (int a = 0; a < RAM_SZ; a += 7) begin
      busRead(16'(a), rd); check("R1 RAM readback", rd, mirror[a]);
    end
    busRead(16'h4000 + 16'd5, rd); check("R1 address wraps", rd, mirror[5]);
    @(negedge clk); busOp = 4'b0000; busAddr = 16'h0005; #1;
    check("R1 idle bus reads zero", busRdData, 0);

    // R2 register map
    busWrite(16'hFE02, 8'h34); busWrite(16'hFE03, 8'h12);
    busWrite(16'hFE04, 8'h78); busWrite(16'hFE05, 8'h56);
    busWrite(16'hFE06, 8'hBC); busWrite(16'hFE07, 8'h9A);
    busRead(16'hFE02, rd); check("R2 src low", rd, 8'h34);
    busRead(16'hFE03, rd); check("R2 src high", rd, 8'h12);
    busRead(16'hFE04, rd); check("R2 dst low", rd, 8'h78);
    busRead(16'hFE05, rd); check("R2 dst high", rd, 8'h56);
    busRead(16'hFE06, rd); check("R2 len low", rd, 8'hBC);
    busRead(16'hFE07, rd); check("R2 len high", rd, 8'h9A);
    busRead(16'hFE00, rd); check("R2 go reads zero", rd, 0);
    for (int o = 8; o < 16; o++) begin
      busWrite(16'hFE00 + 16'(o), 8'h5A);
      busRead(16'hFE00 + 16'(o), rd); check("R2 unused offset zero", rd, 0);
      busRead(16'(o), rd); check("R3 window write spares RAM", rd, mirror[o]);
    end

    // R5 go with bit 0 clear
    busWrite(16'hFE00, 8'h02);
    busRead(16'hFE01, rd); check("R5 go without bit0", rd, 0);
    stepOnce();
    busRead(16'hFE01, rd); check("R7 step in IDLE stays", rd, 0);

    // R8..R12 length sweep, aligned and unaligned source
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 9; k++) begin
        runJob(s == 0 ? 16'h0010 : 16'h0013, 16'h0100, lens[k]);  // k==0 covers R12
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule